// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block decides when a chip sleeps and brings it back up in a fixed, safe order. Software asks for sleep through a one-cycle request. Along with the request it picks a light sleep or a deep sleep, says whether RAM stays powered, and says whether the slow oscillator may stop. Once the CPU domain is down, the block pulses an acknowledge. In light sleep it watches four classes of wake source: pin edges, wake-timer expiry, pulse-counter match and comparator level change. Each class has its own enable.

Every source event is latched into a pending flag, whether or not its class is enabled. Software clears a flag by writing one to it. The sequencer wakes while any enabled flag is set. If several fire together, the lowest-numbered enabled one is reported as the cause and the rest stay pending. Because of this, a sleep request made while an enabled flag is still set wakes again at once.

The wake path runs in order:
1. Wait for supply good.
2. Start the fast oscillator and wait until it is stable.
3. Power the CPU domain for a settle period.
4. Release CPU reset.

Deep sleep turns off every switchable domain, RAM and the slow oscillator. Its only exit is an enabled pin edge, which raises a one-cycle full chip reset and then runs the cold start path. The block's own reset input also exits deep sleep.

Top module: `sleep_wake_seq`

## Requirements
- R1: While reset is held, cpu_rst_o is 1 and cpu_pwr_o, fast_osc_en_o, pending_o, cause_vld_o, ram_kept_o, sleep_ack_o and chip_rst_o are 0. After reset the wake sequence of R8 runs as a cold start.
- R2: Pin edges set pending bit 0. Pin i counts only when pin_mask_i[i] is 1. pin_rise_i[i]=1 selects a rising edge and 0 selects a falling edge. The flag is set at the clock edge that first samples the new pin level.
- R3: Any timer_evt_i bit sets pending bit 1, and any count_evt_i bit sets pending bit 2. Any change of cmp_lvl_i sets pending bit 3. Each flag is set at the edge that samples the event.
- R4: A one in pend_clr_i clears that pending bit at the next edge. An event arriving in the same cycle wins over the clear.
- R5: A pending flag whose src_en_i bit is 0 does not wake the block from light sleep. Enabling that bit later wakes it.
- R6: On wake, wake_cause_o holds the lowest-numbered pending-and-enabled class and cause_vld_o is set. The other pending flags are kept.
- R7: A light-sleep request made while an enabled flag is pending passes through sleep and starts the wake sequence three edges after the request is sampled.
- R8: The wake sequence holds with cpu_rst_o=1 and fast_osc_en_o=0 while supply_ok_i is 0. It then raises fast_osc_en_o and waits for fast_osc_stable_i. Next it raises cpu_pwr_o for SETTLE cycles, and only then clears cpu_rst_o. A wake event driven in sleep gives cpu_rst_o=0 after 4+SETTLE edges.
- R9: If ram_keep_i is 1 at light-sleep entry, ram_pwr_o stays 1 in sleep and ram_kept_o reads 1 after the wake. Otherwise ram_pwr_o is 0 in sleep and ram_kept_o reads 0.
- R10: If slow_off_i is 1 at sleep entry, slow_osc_en_o is 0 during sleep. It returns to 1 at the edge where the wake sequence starts.
- R11: Deep sleep drives ram_pwr_o, slow_osc_en_o, cpu_pwr_o and fast_osc_en_o to 0 and ignores non-pin sources. It also ignores edges on masked pins and edges while src_en_i[0] is 0. An enabled pin edge gives chip_rst_o=1 for one cycle, after which pending_o, cause_vld_o and ram_kept_o are 0 and the cold start path runs.
- R12: sleep_req_i is ignored unless the CPU is out of reset. An accepted request gives sleep_ack_o=1 for exactly one cycle, one edge later, with cpu_pwr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous external reset |
| sleep_req_i | input | 1 | One-cycle sleep request |
| deep_sel_i | input | 1 | 1 selects deep sleep |
| ram_keep_i | input | 1 | Keep RAM powered in light sleep |
| slow_off_i | input | 1 | Stop the slow oscillator in light sleep |
| pin_i | input | N_PIN | Pin wake inputs |
| pin_rise_i | input | N_PIN | Edge polarity per pin, 1 rising, 0 falling |
| pin_mask_i | input | N_PIN | Per-pin wake mask |
| timer_evt_i | input | N_TMR | Wake timer expiry pulses |
| count_evt_i | input | N_CNT | Pulse counter match pulses |
| cmp_lvl_i | input | 1 | Comparator output level |
| src_en_i | input | 4 | Class enables: 0 pin, 1 timer, 2 counter, 3 comparator |
| pend_clr_i | input | 4 | Write-one-to-clear for pending flags |
| supply_ok_i | input | 1 | Supply good |
| fast_osc_stable_i | input | 1 | Fast oscillator stable |
| fast_osc_en_o | output | 1 | Fast oscillator enable |
| slow_osc_en_o | output | 1 | Slow oscillator enable |
| cpu_pwr_o | output | 1 | CPU domain power enable |
| ram_pwr_o | output | 1 | RAM power enable |
| cpu_rst_o | output | 1 | CPU reset, active high |
| chip_rst_o | output | 1 | Full chip reset pulse from deep sleep |
| sleep_ack_o | output | 1 | Domains down, one-cycle pulse |
| pending_o | output | 4 | Pending wake flags |
| wake_cause_o | output | 2 | Class index of the last wake |
| cause_vld_o | output | 1 | wake_cause_o is valid |
| ram_kept_o | output | 1 | RAM was kept through the last sleep |

## Verification
A source event driven between edges appears in pending_o one edge later. sleep_ack_o appears one edge after the request is sampled. From a sleeping state, a wake event reaches cause_vld_o two edges after it is driven and releases cpu_rst_o after 4+SETTLE edges. A deep-sleep pin edge shows on chip_rst_o after one edge, and the flushed state shows after one more. The bench drives inputs on the falling clock edge, advances an exact number of rising edges for each of these latencies, and samples on the following falling edge. It checks the cycle before each release as well as the cycle of it. The random phase compares pending_o every cycle with a bench model of edge detection, set and clear.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  localparam int NUM_CLS = 4;
  localparam int CAUSE_W = $clog2(NUM_CLS);

  localparam int CLS_PIN = 0;
  localparam int CLS_TMR = 1;
  localparam int CLS_CNT = 2;
  localparam int CLS_CMP = 3;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PDN,
    ST_SLEEP,
    ST_DEEP,
    ST_CRST,
    ST_SUPCHK,
    ST_OSCUP,
    ST_DOMON
  } pwr_state_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int N_PIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] pin_rise_i,
  input  logic [N_PIN-1:0] pin_mask_i,
  input  logic             cmp_lvl_i,
  output logic             pin_evt_o,
  output logic             cmp_evt_o
);
  logic             armed_q;
  logic [N_PIN-1:0] pin_q;
  logic             cmp_q;
  logic [N_PIN-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pin_q   <= '0;
      cmp_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      pin_q   <= pin_i;
      cmp_q   <= cmp_lvl_i;
    end
  end

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic rise, fall;
    assign rise   = pin_i[g] & ~pin_q[g];
    assign fall   = ~pin_i[g] & pin_q[g];
    assign hit[g] = pin_mask_i[g] & (pin_rise_i[g] ? rise : fall);
  end

  // first sample after reset only primes history
  assign pin_evt_o = armed_q & (|hit);
  assign cmp_evt_o = armed_q & (cmp_lvl_i ^ cmp_q);
endmodule

// File: rtl/wake_pend.sv
module wake_pend
  import sleep_wake_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int N_CNT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_evt_i,
  input  logic [N_TMR-1:0]   timer_evt_i,
  input  logic [N_CNT-1:0]   count_evt_i,
  input  logic               cmp_evt_i,
  input  logic [NUM_CLS-1:0] clr_i,
  input  logic               flush_i,
  input  logic [NUM_CLS-1:0] en_i,
  output logic [NUM_CLS-1:0] pend_o,
  output logic               wake_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_CLS-1:0] set, pend_q, act;

  always_comb begin
    set          = '0;
    set[CLS_PIN] = pin_evt_i;
    set[CLS_TMR] = |timer_evt_i;
    set[CLS_CNT] = |count_evt_i;
    set[CLS_CMP] = cmp_evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q & ~clr_i) | set;
  end

  assign act    = pend_q & en_i;
  assign wake_o = |act;

  // lowest index wins: last assignment in a descending scan
  always_comb begin
    cause_o = '0;
    for (int i = NUM_CLS - 1; i >= 0; i--) begin
      if (act[i]) cause_o = CAUSE_W'(i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import sleep_wake_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               deep_sel_i,
  input  logic               ram_keep_i,
  input  logic               slow_off_i,
  input  logic               wake_i,
  input  logic               deep_pin_i,
  input  logic               supply_ok_i,
  input  logic               osc_stable_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               fast_osc_en_o,
  output logic               slow_osc_en_o,
  output logic               cpu_pwr_o,
  output logic               ram_pwr_o,
  output logic               cpu_rst_o,
  output logic               chip_rst_o,
  output logic               sleep_ack_o,
  output logic               flush_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               cause_vld_o,
  output logic               ram_kept_o
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic deep_q, keep_q, slow_off_q;
  logic [CAUSE_W-1:0] cause_q;
  logic vld_q, kept_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (sleep_req_i) state_d = ST_PDN;
      ST_PDN:    state_d = deep_q ? ST_DEEP : ST_SLEEP;
      ST_SLEEP:  if (wake_i) state_d = ST_SUPCHK;
      ST_DEEP:   if (deep_pin_i) state_d = ST_CRST;
      ST_CRST:   state_d = ST_SUPCHK;
      ST_SUPCHK: if (supply_ok_i) state_d = ST_OSCUP;
      ST_OSCUP:  if (osc_stable_i) state_d = ST_DOMON;
      ST_DOMON:  if (cnt_q == CNT_LAST) state_d = ST_RUN;
      default:   state_d = ST_SUPCHK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SUPCHK;
      cnt_q      <= '0;
      deep_q     <= 1'b0;
      keep_q     <= 1'b0;
      slow_off_q <= 1'b0;
      cause_q    <= '0;
      vld_q      <= 1'b0;
      kept_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && sleep_req_i) begin
        deep_q     <= deep_sel_i;
        keep_q     <= ram_keep_i & ~deep_sel_i;
        slow_off_q <= slow_off_i;
      end
      if (state_q == ST_SLEEP && wake_i) begin
        cause_q <= cause_i;
        vld_q   <= 1'b1;
        kept_q  <= keep_q;
      end
      if (state_q == ST_CRST) begin
        cause_q <= '0;
        vld_q   <= 1'b0;
        kept_q  <= 1'b0;
        deep_q  <= 1'b0;
      end
      if (state_q == ST_OSCUP) cnt_q <= '0;
      else if (state_q == ST_DOMON) cnt_q <= cnt_q + 1'b1;
    end
  end

  logic asleep;
  assign asleep = (state_q == ST_PDN) || (state_q == ST_SLEEP);

  assign fast_osc_en_o = (state_q == ST_OSCUP) || (state_q == ST_DOMON) || (state_q == ST_RUN);
  assign cpu_pwr_o     = (state_q == ST_DOMON) || (state_q == ST_RUN);
  assign cpu_rst_o     = (state_q != ST_RUN);
  assign sleep_ack_o   = (state_q == ST_PDN);
  assign chip_rst_o    = (state_q == ST_CRST);
  assign flush_o       = (state_q == ST_CRST);

  always_comb begin
    if (state_q == ST_DEEP) begin
      slow_osc_en_o = 1'b0;
      ram_pwr_o     = 1'b0;
    end else if (asleep) begin
      slow_osc_en_o = ~slow_off_q & ~deep_q;
      ram_pwr_o     = keep_q & ~deep_q;
    end else begin
      slow_osc_en_o = 1'b1;
      ram_pwr_o     = 1'b1;
    end
  end

  assign cause_o     = cause_q;
  assign cause_vld_o = vld_q;
  assign ram_kept_o  = kept_q;
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import sleep_wake_pkg::*;
#(
  parameter int N_PIN  = 4,
  parameter int N_TMR  = 2,
  parameter int N_CNT  = 2,
  parameter int SETTLE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic               deep_sel_i,
  input  logic               ram_keep_i,
  input  logic               slow_off_i,
  input  logic [N_PIN-1:0]   pin_i,
  input  logic [N_PIN-1:0]   pin_rise_i,
  input  logic [N_PIN-1:0]   pin_mask_i,
  input  logic [N_TMR-1:0]   timer_evt_i,
  input  logic [N_CNT-1:0]   count_evt_i,
  input  logic               cmp_lvl_i,
  input  logic [NUM_CLS-1:0] src_en_i,
  input  logic [NUM_CLS-1:0] pend_clr_i,
  input  logic               supply_ok_i,
  input  logic               fast_osc_stable_i,
  output logic               fast_osc_en_o,
  output logic               slow_osc_en_o,
  output logic               cpu_pwr_o,
  output logic               ram_pwr_o,
  output logic               cpu_rst_o,
  output logic               chip_rst_o,
  output logic               sleep_ack_o,
  output logic [NUM_CLS-1:0] pending_o,
  output logic [CAUSE_W-1:0] wake_cause_o,
  output logic               cause_vld_o,
  output logic               ram_kept_o
);
  logic pin_evt, cmp_evt, wake, flush;
  logic [CAUSE_W-1:0] cause;

  wake_edge_det #(.N_PIN(N_PIN)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .pin_rise_i (pin_rise_i),
    .pin_mask_i (pin_mask_i),
    .cmp_lvl_i  (cmp_lvl_i),
    .pin_evt_o  (pin_evt),
    .cmp_evt_o  (cmp_evt)
  );

  wake_pend #(.N_TMR(N_TMR), .N_CNT(N_CNT)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_evt_i   (pin_evt),
    .timer_evt_i (timer_evt_i),
    .count_evt_i (count_evt_i),
    .cmp_evt_i   (cmp_evt),
    .clr_i       (pend_clr_i),
    .flush_i     (flush),
    .en_i        (src_en_i),
    .pend_o      (pending_o),
    .wake_o      (wake),
    .cause_o     (cause)
  );

  pwr_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .deep_sel_i    (deep_sel_i),
    .ram_keep_i    (ram_keep_i),
    .slow_off_i    (slow_off_i),
    .wake_i        (wake),
    .deep_pin_i    (pin_evt & src_en_i[CLS_PIN]),
    .supply_ok_i   (supply_ok_i),
    .osc_stable_i  (fast_osc_stable_i),
    .cause_i       (cause),
    .fast_osc_en_o (fast_osc_en_o),
    .slow_osc_en_o (slow_osc_en_o),
    .cpu_pwr_o     (cpu_pwr_o),
    .ram_pwr_o     (ram_pwr_o),
    .cpu_rst_o     (cpu_rst_o),
    .chip_rst_o    (chip_rst_o),
    .sleep_ack_o   (sleep_ack_o),
    .flush_o       (flush),
    .cause_o       (wake_cause_o),
    .cause_vld_o   (cause_vld_o),
    .ram_kept_o    (ram_kept_o)
  );
endmodule

// File: rtl/sleep_wake_seq_chk.sv
module sleep_wake_seq_chk
  import sleep_wake_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               supply_ok_i,
  input logic               fast_osc_en_o,
  input logic               slow_osc_en_o,
  input logic               cpu_pwr_o,
  input logic               ram_pwr_o,
  input logic               cpu_rst_o,
  input logic               chip_rst_o,
  input logic               sleep_ack_o,
  input logic [NUM_CLS-1:0] pending_o
);
  // R12
  ack_pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> (!cpu_pwr_o && cpu_rst_o));

  // R12
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |=> !sleep_ack_o);

  // R8
  pwr_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_pwr_o |-> fast_osc_en_o);

  // R8
  rst_release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> $past(cpu_pwr_o));

  // R8
  osc_after_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fast_osc_en_o) |-> $past(supply_ok_i));

  // R11
  chip_rst_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> (!chip_rst_o && pending_o == '0));

  // R11
  chip_rst_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> (!cpu_pwr_o && !fast_osc_en_o && cpu_rst_o));

  // R1
  run_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_o |-> (cpu_pwr_o && fast_osc_en_o && ram_pwr_o && slow_osc_en_o));
endmodule

bind sleep_wake_seq sleep_wake_seq_chk u_chk (.*);

// File: tb/tb_sleep_wake_seq.sv
module tb_sleep_wake_seq;
  localparam int N_PIN  = 4;
  localparam int N_TMR  = 2;
  localparam int N_CNT  = 2;
  localparam int SETTLE = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req_i = 0, deep_sel_i = 0, ram_keep_i = 0, slow_off_i = 0;
  logic [N_PIN-1:0] pin_i = '0, pin_rise_i = '0, pin_mask_i = '0;
  logic [N_TMR-1:0] timer_evt_i = '0;
  logic [N_CNT-1:0] count_evt_i = '0;
  logic cmp_lvl_i = 0;
  logic [3:0] src_en_i = '0, pend_clr_i = '0;
  logic supply_ok_i = 0, fast_osc_stable_i = 0;
  logic fast_osc_en_o, slow_osc_en_o, cpu_pwr_o, ram_pwr_o, cpu_rst_o;
  logic chip_rst_o, sleep_ack_o, cause_vld_o, ram_kept_o;
  logic [3:0] pending_o;
  logic [1:0] wake_cause_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sleep_wake_seq #(.N_PIN(N_PIN), .N_TMR(N_TMR), .N_CNT(N_CNT), .SETTLE(SETTLE)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i), .deep_sel_i(deep_sel_i),
    .ram_keep_i(ram_keep_i), .slow_off_i(slow_off_i), .pin_i(pin_i), .pin_rise_i(pin_rise_i),
    .pin_mask_i(pin_mask_i), .timer_evt_i(timer_evt_i), .count_evt_i(count_evt_i),
    .cmp_lvl_i(cmp_lvl_i), .src_en_i(src_en_i), .pend_clr_i(pend_clr_i),
    .supply_ok_i(supply_ok_i), .fast_osc_stable_i(fast_osc_stable_i),
    .fast_osc_en_o(fast_osc_en_o), .slow_osc_en_o(slow_osc_en_o), .cpu_pwr_o(cpu_pwr_o),
    .ram_pwr_o(ram_pwr_o), .cpu_rst_o(cpu_rst_o), .chip_rst_o(chip_rst_o),
    .sleep_ack_o(sleep_ack_o), .pending_o(pending_o), .wake_cause_o(wake_cause_o),
    .cause_vld_o(cause_vld_o), .ram_kept_o(ram_kept_o)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pend_next(input logic [3:0] cur, input logic [3:0] clr,
                                           input logic [N_PIN-1:0] p_old, input logic [N_PIN-1:0] p_new,
                                           input logic [N_PIN-1:0] pol, input logic [N_PIN-1:0] msk,
                                           input logic tmr, input logic cnt, input logic cmp_chg);
    logic [3:0] s;
    logic [N_PIN-1:0] e;
    e = msk & ((pol & p_new & ~p_old) | (~pol & ~p_new & p_old));
    s = {cmp_chg, cnt, tmr, |e};
    return (cur & ~clr) | s;
  endfunction

  task automatic wait_run(input string tag);
    int n = 0;
    while (cpu_rst_o && n < 40) begin
      tick();
      n++;
    end
    check(tag, cpu_rst_o, 0);
  endtask

  task automatic quiet();
    timer_evt_i = '0; count_evt_i = '0; pend_clr_i = '0;
    pin_i = '0; cmp_lvl_i = 0;
    tick(2);
    pend_clr_i = 4'hF;
    tick();
    pend_clr_i = '0;
  endtask

  // request sleep; returns sampled in the sleep or deep state
  task automatic do_sleep(input logic deep, input logic keep, input logic off);
    deep_sel_i = deep; ram_keep_i = keep; slow_off_i = off; sleep_req_i = 1;
    tick();
    sleep_req_i = 0;
    check("R12 ack pulse", sleep_ack_o, 1);
    check("R12 cpu power off at ack", cpu_pwr_o, 0);
    tick();
    check("R12 ack single cycle", sleep_ack_o, 0);
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_pend;
    logic [N_PIN-1:0] p_old;
    logic c_old;
    void'($urandom(32'd4242));

    tick(2);
    // R1 reset state
    check("R1 cpu_rst", cpu_rst_o, 1);
    check("R1 cpu_pwr", cpu_pwr_o, 0);
    check("R1 fast_osc", fast_osc_en_o, 0);
    check("R1 pending", pending_o, 0);
    check("R1 vld/kept/ack/chip", {cause_vld_o, ram_kept_o, sleep_ack_o, chip_rst_o}, 0);
    rst_ni = 1;
    tick(3);
    check("R8 hold on bad supply rst", cpu_rst_o, 1);
    check("R8 hold on bad supply osc", fast_osc_en_o, 0);
    supply_ok_i = 1;
    tick();
    check("R8 osc start", fast_osc_en_o, 1);
    check("R8 no power before stable", cpu_pwr_o, 0);
    sleep_req_i = 1;       // R12: ignored while not running
    tick();
    sleep_req_i = 0;
    tick();
    check("R8 wait stable", cpu_pwr_o, 0);
    fast_osc_stable_i = 1;
    tick();
    check("R8 domain on", cpu_pwr_o, 1);
    check("R8 reset held in settle", cpu_rst_o, 1);
    tick(SETTLE - 1);
    check("R8 reset held last settle", cpu_rst_o, 1);
    tick();
    check("R8 reset released", cpu_rst_o, 0);
    tick(3);
    check("R12 request outside run ignored", {sleep_ack_o, cpu_rst_o}, 0);

    // random phase: R2 R3 R4
    pin_rise_i = N_PIN'($urandom);
    pin_mask_i = N_PIN'($urandom) | 1;
    exp_pend = pending_o;
    p_old = pin_i;
    c_old = cmp_lvl_i;
    for (int it = 0; it < 400; it++) begin
      logic [N_PIN-1:0] pn;
      logic cn;
      pn = (($urandom % 3) == 0) ? N_PIN'($urandom) : p_old;
      cn = (($urandom % 6) == 0) ? ~c_old : c_old;
      pin_i = pn;
      cmp_lvl_i = cn;
      timer_evt_i = (($urandom % 7) == 0) ? N_TMR'($urandom) : '0;
      count_evt_i = (($urandom % 7) == 0) ? N_CNT'($urandom) : '0;
      pend_clr_i = (($urandom % 4) == 0) ? 4'($urandom) : '0;
      src_en_i = 4'($urandom);
      exp_pend = pend_next(exp_pend, pend_clr_i, p_old, pn, pin_rise_i, pin_mask_i,
                           |timer_evt_i, |count_evt_i, cn ^ c_old);
      tick();
      check("R2 R3 R4 pending model", pending_o, exp_pend);
      p_old = pn;
      c_old = cn;
    end
    quiet();
    check("R4 clear all", pending_o, 0);

    // R4 set wins over clear
    timer_evt_i = 2'b01; pend_clr_i = 4'b0010;
    tick();
    timer_evt_i = '0; pend_clr_i = '0;
    check("R4 set beats clear", pending_o, 4'b0010);
    pend_clr_i = 4'b0010;
    tick();
    pend_clr_i = '0;
    check("R4 w1c", pending_o, 0);

    // simultaneous wake, retention, slow osc off: R6 R8 R9 R10
    src_en_i = 4'hF;
    do_sleep(0, 1, 1);
    check("R10 slow osc off", slow_osc_en_o, 0);
    check("R9 ram kept on", ram_pwr_o, 1);
    timer_evt_i = 2'b01; count_evt_i = 2'b10; cmp_lvl_i = 1;
    tick();
    timer_evt_i = '0; count_evt_i = '0;
    check("R6 all latched", pending_o, 4'b1110);
    tick();
    check("R10 slow osc restart", slow_osc_en_o, 1);
    check("R6 cause lowest", {cause_vld_o, wake_cause_o}, 3'b101);
    check("R6 others pending", pending_o, 4'b1110);
    tick(1 + SETTLE);
    check("R8 wake latency minus one", cpu_rst_o, 1);
    tick();
    check("R8 wake latency", cpu_rst_o, 0);
    check("R9 ram kept flag", ram_kept_o, 1);

    // R7 immediate rewake; R9 without retention
    pend_clr_i = 4'b0010;
    tick();
    pend_clr_i = '0;
    do_sleep(0, 0, 0);
    check("R9 ram off in sleep", ram_pwr_o, 0);
    check("R10 slow osc stays on", slow_osc_en_o, 1);
    tick();
    check("R7 rewake cause", {cause_vld_o, wake_cause_o}, 3'b110);
    wait_run("R7 rewake run");
    check("R9 ram not kept", ram_kept_o, 0);

    // R5 disabled source
    quiet();
    src_en_i = 4'b1101;
    do_sleep(0, 0, 0);
    timer_evt_i = 2'b10;
    tick();
    timer_evt_i = '0;
    tick(9);
    check("R5 still asleep", {cpu_rst_o, fast_osc_en_o}, 2'b10);
    check("R5 flag pending", pending_o, 4'b0010);
    src_en_i = 4'hF;
    tick();
    check("R5 wake on enable", {cause_vld_o, wake_cause_o}, 3'b101);
    wait_run("R5 run");

    // R11 deep sleep
    quiet();
    pin_rise_i = 4'b0011; pin_mask_i = 4'b0001; src_en_i = 4'hF;
    do_sleep(1, 1, 0);
    check("R11 deep dark", {ram_pwr_o, slow_osc_en_o, cpu_pwr_o, fast_osc_en_o}, 0);
    timer_evt_i = 2'b11; count_evt_i = 2'b01; cmp_lvl_i = 1;
    tick();
    timer_evt_i = '0; count_evt_i = '0;
    pin_i[1] = 1;
    tick(4);
    check("R11 other sources ignored", {chip_rst_o, cpu_rst_o, fast_osc_en_o}, 3'b010);
    src_en_i[0] = 0;
    pin_i[0] = 1;
    tick(3);
    check("R11 pin class disabled", {chip_rst_o, cpu_rst_o, ram_pwr_o}, 3'b010);
    pin_i[0] = 0;
    tick();
    src_en_i[0] = 1;
    pin_i[0] = 1;
    tick();
    check("R11 chip reset", chip_rst_o, 1);
    tick();
    check("R11 chip reset single", chip_rst_o, 0);
    check("R11 flushed", {pending_o, cause_vld_o, ram_kept_o}, 0);
    wait_run("R11 cold start");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule